// File: doc/BRIEF.md
# Channel-Status Bit Sequencer for a Digital Audio Transmitter

This block feeds a serial audio transmitter one channel-status bit per frame. Six 32-bit status words are presented together on one flat input bus, word A in the lowest bits and word F in the highest. Together they form a 192-bit channel-status block. At each frame boundary, marked by a one-cycle frame strobe, the block either shifts its internal register by one bit or loads the next word. The transmitter copies the current bit into the frame it is building.

A sequence starts on the first frame strobe that finds both the transmit enable and the channel-status enable high. On that strobe word A is loaded and the busy flag rises. Busy tracks the register loads. It drops when word F is loaded, even though the 32 bits of F are still being sent. It also drops at the frame boundary where transmit turns out to be disabled. After the last bit of F, the block idles until the enables have been withdrawn and granted again.

Top module: `cs_tx_sequencer`

## Requirements
- R1: After reset, cs_bit is 0 and cs_busy is 0.
- R2: Word A (cs_block[31:0]) is loaded only on a frame strobe that finds tx_en and cs_en both high; cs_busy rises on that same clock edge, and no load happens while no strobe arrives.
- R3: Each word is sent least significant bit first. After the strobe that loads A, cs_bit equals cs_block bit 0, and after j further strobes it equals cs_block bit j.
- R4: A new word is loaded after its predecessor has been shown for 32 frames, in the order A, B, C, D, E, F. Word n occupies cs_block[32n+31:32n].
- R5: cs_busy falls on the strobe that loads word F (the 160th strobe after the one that loaded A), while the bits of F continue to appear on cs_bit.
- R6: On the strobe after the last bit of F, cs_bit goes to 0 and remains 0 with cs_busy low, whatever further strobes arrive. A new sequence starts only after tx_en or cs_en has been low and both are high again at a strobe.
- R7: If tx_en is low at a frame strobe during a sequence, the sequence ends on that edge with cs_busy low and cs_bit 0. Before that strobe, cs_busy stays high.
- R8: While cs_en is low, cs_bit is 0 at once, without waiting for a strobe. A strobe seen with cs_en low loads nothing and ends any running sequence with cs_busy low.
- R9: A strobe with only one of the two enables high loads nothing and leaves cs_busy low.
- R10: A word is sampled when it is loaded. Changes on cs_block after that do not alter the bits being sent from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| cs_en | input | 1 | Channel-status enable |
| frame_strobe | input | 1 | One-cycle pulse at each frame boundary |
| cs_block | input | 192 | Six status words; word A in bits 31:0, word F in bits 191:160 |
| cs_bit | output | 1 | Channel-status bit for the current frame |
| cs_busy | output | 1 | High from the load of word A until the load of word F or an early stop |

## Verification
On every cycle, the assertions check the following:
- busy can only rise on an enabled strobe and can only fall on a strobe;
- a strobe with either enable low leaves busy low afterwards;
- the shift register and word index hold between strobes and move only at word boundaries;
- the stopped state drives no bit.

Only the bench's scenarios can show the rest, because the assertions do not compute it:
- the exact bit order across all 192 frames;
- busy falling exactly at the F load;
- restarting after a stop;
- immunity to input changes after a word has been captured.

// File: rtl/cs_tx_sequencer.sv
module cs_tx_sequencer #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tx_en,
  input  logic                        cs_en,
  input  logic                        frame_strobe,
  input  logic [NUM_WORDS*WORD_W-1:0] cs_block,
  output logic                        cs_bit,
  output logic                        cs_busy
);

  localparam int BW = $clog2(WORD_W);
  localparam int IW = $clog2(NUM_WORDS);
  localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_W - 1);
  localparam logic [IW-1:0] LAST_WORD = IW'(NUM_WORDS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_t;

  st_t             st;
  logic [WORD_W-1:0] shreg;
  logic [BW-1:0]     bcnt;
  logic [IW-1:0]     widx;
  logic [IW-1:0]     nidx;
  logic [WORD_W-1:0] nword;
  logic              both_en;

  assign both_en = tx_en && cs_en;
  assign nidx    = (st == ST_IDLE) ? '0 : widx + 1'b1;
  assign nword   = cs_block[int'(nidx)*WORD_W +: WORD_W];
  assign cs_bit  = cs_en && (st == ST_RUN) && shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      shreg   <= '0;
      bcnt    <= '0;
      widx    <= '0;
      cs_busy <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (frame_strobe && both_en) begin
            shreg   <= nword;
            widx    <= '0;
            bcnt    <= '0;
            cs_busy <= (NUM_WORDS > 1);
            st      <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (frame_strobe) begin
            if (!both_en) begin
              st      <= ST_IDLE;
              cs_busy <= 1'b0;
            end else if (bcnt == LAST_BIT) begin
              if (widx == LAST_WORD) begin
                st <= ST_DONE;
              end else begin
                shreg <= nword;
                widx  <= nidx;
                bcnt  <= '0;
                if (nidx == LAST_WORD) cs_busy <= 1'b0;
              end
            end else begin
              shreg <= shreg >> 1;
              bcnt  <= bcnt + 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (!both_en) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // busy may only rise on a strobe that sees both enables
  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_busy) |-> $past(frame_strobe && tx_en && cs_en));

  // nothing in the shifter moves between frame boundaries
  assert_hold_between_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> $stable(shreg) && $stable(widx) && $stable(cs_busy));

  // word index only advances after the last bit of a word
  assert_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && frame_strobe && both_en && bcnt != LAST_BIT) |=> $stable(widx));

  // busy drops only at a frame boundary
  assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_busy) |-> $past(frame_strobe));

  // the stopped sequence drives no status bit and no busy
  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |-> (!cs_bit && !cs_busy));

  // a strobe with transmit off ends the sequence
  assert_tx_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && !tx_en) |=> !cs_busy);

  // a strobe with channel status off leaves busy low
  assert_cs_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && !cs_en) |=> !cs_busy);

endmodule

// File: tb/tb_cs_tx_sequencer.sv
module tb_cs_tx_sequencer;
  localparam int WORD_W = 32;
  localparam int NUM_WORDS = 6;
  localparam int TOT = WORD_W * NUM_WORDS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic cs_en = 1'b0;
  logic frame_strobe = 1'b0;
  logic [TOT-1:0] cs_block = '0;
  logic cs_bit, cs_busy;

  int n_chk = 0;
  int n_bad = 0;

  logic [TOT-1:0] blk;

  // {frame index j, expected busy}
  localparam logic [8:0] TBL [10] = '{
    {8'd0, 1'b1}, {8'd1, 1'b1}, {8'd31, 1'b1}, {8'd32, 1'b1}, {8'd63, 1'b1},
    {8'd100, 1'b1}, {8'd159, 1'b1}, {8'd160, 1'b0}, {8'd175, 1'b0}, {8'd191, 1'b0}
  };

  cs_tx_sequencer #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cs_en(cs_en),
    .frame_strobe(frame_strobe), .cs_block(cs_block),
    .cs_bit(cs_bit), .cs_busy(cs_busy)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) frame_strobe = 1'b1;
    @(negedge clk) frame_strobe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int j;
    blk = {32'hC3A5_0F1E, 32'h9B6D_2471, 32'h0F0F_A55A, 32'h7E81_3CC3,
           32'hDEAD_BEEF, 32'h1234_5679};
    cs_block = blk;
    idle(3);
    chk("R1 bit", cs_bit, 1'b0);
    chk("R1 busy", cs_busy, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);

    // R9: a single enable is not enough
    tx_en = 1'b1; cs_en = 1'b0;
    strobe();
    chk("R9 busy tx only", cs_busy, 1'b0);
    tx_en = 1'b0; cs_en = 1'b1;
    strobe();
    chk("R9 busy cs only", cs_busy, 1'b0);
    chk("R9 bit cs only", cs_bit, 1'b0);

    // R2: no load without a strobe
    tx_en = 1'b1;
    idle(5);
    chk("R2 no strobe busy", cs_busy, 1'b0);
    strobe();
    j = 0;
    chk("R2 busy on A load", cs_busy, 1'b1);
    // R10: corrupt word A on the input after capture
    cs_block[31:0] = ~blk[31:0];

    for (int i = 0; i < 10; i++) begin
      while (j < int'(TBL[i][8:1])) begin strobe(); j++; end
      chk($sformatf("R3/R4 bit j=%0d", j), cs_bit, blk[j]);
      chk($sformatf("R5 busy j=%0d", j), cs_busy, TBL[i][0]);
      if (j > 0 && j < 32) chk($sformatf("R10 bit j=%0d", j), cs_bit, blk[j]);
    end

    // R6: sequence stops after the last bit of F
    strobe();
    chk("R6 bit after end", cs_bit, 1'b0);
    chk("R6 busy after end", cs_busy, 1'b0);
    cs_block = blk;
    strobe(); strobe();
    chk("R6 no restart bit", cs_bit, 1'b0);
    chk("R6 no restart busy", cs_busy, 1'b0);
    cs_en = 1'b0; idle(2); cs_en = 1'b1;
    strobe();
    chk("R6 restart busy", cs_busy, 1'b1);
    chk("R6 restart bit", cs_bit, blk[0]);

    // R7: transmit disabled mid-run
    for (int k = 0; k < 10; k++) strobe();
    tx_en = 1'b0;
    idle(3);
    chk("R7 busy held before strobe", cs_busy, 1'b1);
    strobe();
    chk("R7 busy at frame end", cs_busy, 1'b0);
    chk("R7 bit at frame end", cs_bit, 1'b0);
    tx_en = 1'b1;
    strobe();
    chk("R7 reload busy", cs_busy, 1'b1);
    chk("R7 reload bit", cs_bit, blk[0]);

    // R8: channel status disabled mid-run, on a 1 bit
    j = 0;
    while (j < 2 || blk[j] == 1'b0) begin strobe(); j++; end
    chk("R8 bit before disable", cs_bit, 1'b1);
    cs_en = 1'b0;
    #1;
    chk("R8 bit forced low", cs_bit, 1'b0);
    strobe();
    chk("R8 busy after strobe", cs_busy, 1'b0);
    cs_en = 1'b1;
    idle(2);
    chk("R8 no load without strobe", cs_bit, 1'b0);
    chk("R8 busy stays low", cs_busy, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule